// File: doc/BRIEF.md
# Watchdog Timer with Shared Postscaler

This block is the watchdog of a small microcontroller core. A down counter advances once per instruction-cycle tick while the watchdog enable fuse bit is set. The counter wraps with a fixed period. Each wrap to zero is an expiry. The counter keeps running while the core is asleep, so an expiry can wake a sleeping core.

The core has one scaler, shared between the timer and the watchdog. When the scaler is given to the timer, every watchdog expiry raises a reset request at once. When the scaler is given to the watchdog, it acts as a postscaler. Each expiry bumps it, and the reset request is raised only when its count reaches two to the power of the selected rate, so between 1 and 128 expiries are needed.

Two software commands act on the watchdog. The clear command restarts the watchdog. The sleep command restarts it and enters power-down. The block also keeps the two status flags that software reads after a reset: the timeout flag and the power-down flag.

Top module: `watchdog_postscaled`

## Requirements
- R1: After the synchronous power-on reset, `reset_req` is 0, `no_timeout` is 1 and `not_asleep` is 1. The watchdog count and the scaler count are both 0.
- R2: While `wdt_enable` is 1, the count moves one step on each `cyc_tick`. From count 0 it steps to PERIOD-1, and from any other value it steps down by one. Reaching 0 is an expiry, so after a clear the first expiry comes on the PERIOD-th counted tick, and then every PERIOD counted ticks.
- R3: With `scaler_to_wdt` = 0, every expiry makes `reset_req` 1 for exactly one cycle, on the cycle that follows the expiring tick edge.
- R4: With `scaler_to_wdt` = 1, an expiry raises `reset_req` when the scaler count plus one is at least 2^`scaler_rate` (`scaler_rate` 0 to 7 gives 1 to 128 expiries). Otherwise the expiry only adds one to the scaler count.
- R5: `clr_cmd` zeroes the watchdog count and sets both `no_timeout` and `not_asleep`. It zeroes the scaler count only when `scaler_to_wdt` is 1. If `clr_cmd` and `sleep_cmd` arrive together, `clr_cmd` wins.
- R6: `sleep_cmd` sets `no_timeout` and clears `not_asleep`. It zeroes the watchdog count only when `wdt_enable` is 1. It zeroes the scaler count only when `scaler_to_wdt` is 1.
- R7: A tick that arrives in the same cycle as `clr_cmd` or `sleep_cmd` does not move the watchdog count.
- R8: While `wdt_enable` is 0, the count holds and no reset request is made, however many ticks arrive. The count does not depend on `not_asleep`, so it also runs during sleep.
- R9: When the watchdog raises a reset request, it clears `no_timeout`, sets `not_asleep` and zeroes the scaler count. `no_timeout` then stays 0 until the next clear or sleep command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cyc_tick | input | 1 | One pulse per instruction cycle |
| wdt_enable | input | 1 | Watchdog enable fuse bit |
| scaler_to_wdt | input | 1 | 1 = shared scaler serves the watchdog as postscaler |
| scaler_rate | input | RATE_W | Rate select; the postscaler ratio is 2^rate |
| clr_cmd | input | 1 | Clear-watchdog command strobe |
| sleep_cmd | input | 1 | Sleep command strobe |
| reset_req | output | 1 | One-cycle device reset request |
| no_timeout | output | 1 | Timeout status flag (0 after a watchdog reset) |
| not_asleep | output | 1 | Power-down status flag (0 after sleep) |

## Verification
The bench places the expiry exactly. A counter that is off by one in its reload, or that lets a tick pass in the same cycle as a clear or sleep command, moves the reset request by one tick. With the postscaler assigned at several rates, a design that compares with the wrong bound resets one expiry early or late. A design that forgets to zero the scaler after a reset stretches the next interval. The bench also switches the scaler assignment while the scaler count is non-zero, and issues sleep with the enable fuse bit at 0. In those cases a design that clears the scaler or the count when it should not shows up as a shifted reset later on.

// File: rtl/wdt_ps_pkg.sv
package wdt_ps_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_CLEAR = 2'd1,
        CMD_SLEEP = 2'd2
    } wdt_cmd_e;

    function automatic wdt_cmd_e decode_cmd(input logic clr, input logic slp);
        if (clr)      return CMD_CLEAR;
        else if (slp) return CMD_SLEEP;
        else          return CMD_NONE;
    endfunction

    typedef struct packed {
        logic fire;
        logic bump;
        logic wipe;
    } scaler_act_t;

endpackage

// File: rtl/wd_downcount.sv
module wd_downcount
    import wdt_ps_pkg::*;
#(
    parameter int PERIOD = 18000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     en,
    input  wdt_cmd_e cmd,
    output logic     expire_o
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LOAD = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic          active;

    always_comb begin
        active   = tick && en && (cmd == CMD_NONE);
        cnt_nxt  = (cnt_q == '0) ? LOAD : cnt_q - 1'b1;
        expire_o = active && (cnt_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cmd == CMD_CLEAR || (cmd == CMD_SLEEP && en)) begin
            cnt_q <= '0;
        end else if (active) begin
            cnt_q <= cnt_nxt;
        end
    end

    // R5
    count_zero_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_CLEAR) |=> (cnt_q == '0));

    // R8
    count_holds_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && cmd != CMD_CLEAR) |=> $stable(cnt_q));

    // R7
    no_step_on_command_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NONE) |-> !expire_o);

endmodule

// File: rtl/wd_postscaler.sv
module wd_postscaler
    import wdt_ps_pkg::*;
#(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              expire,
    input  logic              assigned,
    input  logic [RATE_W-1:0] rate,
    input  wdt_cmd_e          cmd,
    output logic              fire_o
);
    localparam int SW = 2 ** RATE_W;

    logic [SW-1:0] ps_q;
    logic [SW:0]   ps_plus;
    logic [SW:0]   bound;
    scaler_act_t   act;

    always_comb begin
        ps_plus  = {1'b0, ps_q} + (SW + 1)'(1);
        bound    = (SW + 1)'(1) << rate;
        act.fire = expire && (!assigned || (ps_plus >= bound));
        act.bump = expire && assigned && !act.fire;
        act.wipe = act.fire || (assigned && cmd != CMD_NONE);
        fire_o   = act.fire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ps_q <= '0;
        end else if (act.wipe) begin
            ps_q <= '0;
        end else if (act.bump) begin
            ps_q <= ps_plus[SW-1:0];
        end
    end

    // R9
    scaler_zero_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> (ps_q == '0));

    // R5
    scaler_kept_unassigned_chk: assert property (@(posedge clk) disable iff (rst)
        (!assigned && !expire) |=> $stable(ps_q));

endmodule

// File: rtl/wd_status.sv
module wd_status
    import wdt_ps_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     fire,
    input  wdt_cmd_e cmd,
    output logic     reset_req_o,
    output logic     no_timeout_o,
    output logic     not_asleep_o
);
    logic req_q, to_q, pd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            to_q  <= 1'b1;
            pd_q  <= 1'b1;
        end else begin
            req_q <= fire;
            if (fire) begin
                to_q <= 1'b0;
                pd_q <= 1'b1;
            end else if (cmd == CMD_CLEAR) begin
                to_q <= 1'b1;
                pd_q <= 1'b1;
            end else if (cmd == CMD_SLEEP) begin
                to_q <= 1'b1;
                pd_q <= 1'b0;
            end
        end
    end

    assign reset_req_o  = req_q;
    assign no_timeout_o = to_q;
    assign not_asleep_o = pd_q;

    // R9
    timeout_cleared_on_reset_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req_o |-> (!no_timeout_o && not_asleep_o));

    // R6
    sleep_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_SLEEP) |=> (no_timeout_o && !not_asleep_o));

endmodule

// File: rtl/watchdog_postscaled.sv
module watchdog_postscaled
    import wdt_ps_pkg::*;
#(
    parameter int PERIOD = 18000,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_tick,
    input  logic              wdt_enable,
    input  logic              scaler_to_wdt,
    input  logic [RATE_W-1:0] scaler_rate,
    input  logic              clr_cmd,
    input  logic              sleep_cmd,
    output logic              reset_req,
    output logic              no_timeout,
    output logic              not_asleep
);
    wdt_cmd_e cmd;
    logic     expire;
    logic     fire;

    assign cmd = decode_cmd(clr_cmd, sleep_cmd);

    wd_downcount #(.PERIOD(PERIOD)) u_count (
        .clk(clk), .rst(rst), .tick(cyc_tick), .en(wdt_enable),
        .cmd(cmd), .expire_o(expire)
    );

    wd_postscaler #(.RATE_W(RATE_W)) u_scale (
        .clk(clk), .rst(rst), .expire(expire), .assigned(scaler_to_wdt),
        .rate(scaler_rate), .cmd(cmd), .fire_o(fire)
    );

    wd_status u_stat (
        .clk(clk), .rst(rst), .fire(fire), .cmd(cmd),
        .reset_req_o(reset_req), .no_timeout_o(no_timeout),
        .not_asleep_o(not_asleep)
    );

    // R3
    single_cycle_request_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    // R8
    no_request_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !wdt_enable |=> !reset_req);

    // R5
    clear_sets_flags_chk: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> (no_timeout && not_asleep && !reset_req));

endmodule

// File: tb/watchdog_postscaled_test.sv
module watchdog_postscaled_test;
    localparam int PER = 12;
    localparam int RW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0, en = 1'b0, psa = 1'b0, clr = 1'b0, slp = 1'b0;
    logic [RW-1:0] rate = '0;
    logic          req, nto, nas;

    int n_chk = 0, n_bad = 0;
    int m_cnt, m_ps;
    bit m_to, m_pd, m_req;

    always #10 clk = ~clk;

    watchdog_postscaled #(.PERIOD(PER), .RATE_W(RW)) uut (
        .clk(clk), .rst(rst), .cyc_tick(tick), .wdt_enable(en),
        .scaler_to_wdt(psa), .scaler_rate(rate), .clr_cmd(clr),
        .sleep_cmd(slp), .reset_req(req), .no_timeout(nto), .not_asleep(nas)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // expected next state from the requirements
    function automatic bit fires(input int ps, input bit assigned, input int r);
        return !assigned || (ps + 1 >= (1 << r));
    endfunction

    task automatic model_step(output string tag);
        int nxt;
        m_req = 0;
        tag = "R2";
        if (clr) begin
            m_cnt = 0; m_to = 1; m_pd = 1;
            if (psa) m_ps = 0;
            tag = "R5";
        end else if (slp) begin
            if (en) m_cnt = 0;
            m_to = 1; m_pd = 0;
            if (psa) m_ps = 0;
            tag = "R6";
        end else if (tick && en) begin
            nxt = (m_cnt == 0) ? PER - 1 : m_cnt - 1;
            m_cnt = nxt;
            if (nxt == 0) begin
                tag = psa ? "R4" : "R3";
                if (fires(m_ps, psa, int'(rate))) begin
                    m_req = 1; m_to = 0; m_pd = 1; m_ps = 0;
                end else begin
                    m_ps++;
                end
            end
        end
    endtask

    task automatic step(input bit t, input bit c, input bit s, input string force_tag);
        string tag;
        @(negedge clk);
        tick = t; clr = c; slp = s;
        model_step(tag);
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        #2;
        check(tag, "reset_req", int'(req), int'(m_req));
        check(tag, "no_timeout", int'(nto), int'(m_to));
        check(tag, "not_asleep", int'(nas), int'(m_pd));
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_cnt = 0; m_ps = 0; m_to = 1; m_pd = 1; m_req = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "reset_req", int'(req), 0);
        check("R1", "no_timeout", int'(nto), 1);
        check("R1", "not_asleep", int'(nas), 1);

        // R2 / R3: exact period, direct reset
        en = 1; psa = 0;
        step(0, 1, 0, "R5");
        for (int i = 0; i < PER - 1; i++) step(1, 0, 0, "R2");
        step(1, 0, 0, "R3");
        check("R3", "pulse_seen", int'(req), 1);
        step(0, 0, 0, "R3");
        check("R3", "pulse_one_cycle", int'(req), 0);
        // R9: timeout flag stays cleared while idle
        for (int i = 0; i < 5; i++) step(0, 0, 0, "R9");
        check("R9", "no_timeout_held", int'(nto), 0);

        // R7: ticks coincident with commands do not count
        step(1, 1, 0, "R7");
        step(1, 0, 1, "R7");
        step(1, 1, 1, "R7");
        for (int i = 0; i < PER - 1; i++) step(1, 0, 0, "R7");
        step(1, 0, 0, "R7");
        check("R7", "expiry_after_full_period", int'(req), 1);

        // R8: disabled, no count
        en = 0;
        step(1, 0, 1, "R8");
        for (int i = 0; i < 3 * PER; i++) step(1, 0, 0, "R8");
        en = 1;
        // R8: runs while asleep
        step(0, 0, 1, "R6");
        for (int i = 0; i < PER; i++) step(1, 0, 0, "R8");
        check("R8", "wake_reset_in_sleep", int'(req), 1);

        // R4: postscaler rates 0, 2, 3
        psa = 1;
        for (int r = 0; r < 4; r += (r == 0) ? 2 : 1) begin
            rate = RW'(r);
            step(0, 1, 0, "R5");
            for (int i = 0; i < (PER << r) - 1; i++) step(1, 0, 0, "R4");
            check("R4", "no_early_reset", int'(req), 0);
            step(1, 0, 0, "R4");
            check("R4", "reset_at_ratio", int'(req), 1);
        end

        // R5: clear with scaler unassigned keeps scaler count
        rate = 2;
        step(0, 1, 0, "R5");
        for (int i = 0; i < PER; i++) step(1, 0, 0, "R4");
        psa = 0;
        step(0, 1, 0, "R5");
        psa = 1;
        for (int i = 0; i < 3 * PER; i++) step(1, 0, 0, "R5");
        check("R5", "scaler_kept", int'(m_req), 1);

        // mixed random traffic
        for (int i = 0; i < 30000; i++) begin
            if (($urandom % 200) == 0) psa = $urandom % 2;
            if (($urandom % 150) == 0) rate = RW'($urandom % 4);
            if (($urandom % 300) == 0) en = ($urandom % 8) != 0;
            step(($urandom % 4) != 0, ($urandom % 400) == 0,
                 ($urandom % 500) == 0, "");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule